// File: doc/BRIEF.md
# Scan Chain Suspect Range Bounder

This block narrows down where a defect sits inside one failing scan chain. After a start pulse it takes cell records one per clock, in order of cell index from the output end (index 0) up to the input end (index N-1). Each record holds the simulated value and a flag saying whether that value is known, the value read back from silicon, and the cell's polarity. It repeats this for as many unload patterns as the diagnosis uses. The fault class under test is sampled with the start pulse.

Each qualifying cell, or pair of adjacent cells, gives one of two results. Either the defect must lie above some index, which raises a lower bound. Or it must lie at or below some index, which lowers an upper bound. Both bounds only ever tighten. When the last cell of the pattern marked as final has been taken, the block raises its done flag and stops accepting data. The surviving range is then the list of candidate cells for scoring. If the evidence contradicts itself, the lower bound passes the upper bound and a sticky conflict flag is set.

Top module: `scan_suspect_bounder`

## Requirements
- R1: After reset, and again after each start pulse, the lower bound is 0, the upper bound is N-1 and the conflict flag is 0. Ready and done are 0 after reset. Ready is 1 from the cycle after start.
- R2: A cell whose known flag is 0 never changes either bound, whether it stands alone or as one half of a pair.
- R3: Fault codes are 3 bits: 0 stuck-at-0, 1 stuck-at-1, 2 slow rise, 3 slow fall, 4 fast rise, 5 fast fall, 6 hold, 7 no rule. The polarity input is 1 for a negative cell. The normalised value is the simulated value XOR polarity. For stuck-at-a (a is bit 0 of the code), a known cell is used only when its normalised value differs from a.
- R4: For a stuck-at cell c that is used: if observed equals simulated, the lower bound becomes max(lower, c+1); otherwise the upper bound becomes min(upper, c).
- R5: For the transition codes, the pair (c-1, c) is used only when both cells are known and c > 0. The normalised values must be (0,1) for the rise codes 2 and 4, or (1,0) for the fall codes 3 and 5.
- R6: For a pair that is used: if both cells read back their simulated values, the lower bound becomes max(lower, c); otherwise the upper bound becomes min(upper, c-1).
- R7: For the hold code 6, a pair of known cells is used when the two raw simulated values differ, whatever the polarities. Code 7 changes nothing.
- R8: Bounds only tighten across patterns. The cell index wraps to 0 after cell N-1. Cell 0 of a pattern never forms a pair with the last cell of the previous pattern.
- R9: The conflict flag becomes 1 in the cycle the lower bound first exceeds the upper bound. It stays 1 until the next start.
- R10: A cell is taken only in a cycle where valid and ready are both 1, at up to one cell per clock. Data offered while ready is 0 has no effect.
- R11: When the last cell of a pattern is taken with the final-pattern input at 1, done becomes 1 and ready becomes 0 on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that begins a diagnosis and samples the fault code |
| fault_i | input | 3 | Fault class code (R3) |
| cell_valid_i | input | 1 | A cell record is offered |
| cell_sim_i | input | 1 | Simulated value of the cell |
| cell_known_i | input | 1 | 1 when the simulated value is binary |
| cell_obs_i | input | 1 | Value observed on the tester |
| cell_neg_i | input | 1 | 1 for a negative-polarity cell |
| final_pat_i | input | 1 | Marks the current pattern as the last; sampled with cell N-1 |
| cell_ready_o | output | 1 | Block accepts a cell |
| lo_o | output | IDX_W+1 | Lower bound of the suspect range (may reach N) |
| hi_o | output | IDX_W | Upper bound of the suspect range |
| conflict_o | output | 1 | Sticky flag: lower bound exceeded upper bound |
| done_o | output | 1 | Final pattern fully consumed |

## Verification
The directed streams are built to separate one rule from another:
- A stuck-at-1 stream with a negative cell tells normalised marking from raw marking.
- An alternating stream under slow rise tells the match case of the pair rule from the mismatch case.
- Two cells with equal normalised values but different raw values tell the hold rule from the transition rule.
- An all-unknown stream, a stream that splits a pair across two patterns, and data offered while not ready must all leave the bounds where they were.
- A stream that pushes the lower bound to N shows the conflict flag setting and then holding.

A sweep then runs every fault code over pseudo-random streams on a chain of 8 cells, with random known flags, polarities and read-back flips. After each pattern the bounds and the conflict flag are compared with values computed in the bench from the rules.

// File: rtl/scb_pkg.sv
package scb_pkg;
  typedef enum logic [2:0] {
    FT_SA0       = 3'd0,
    FT_SA1       = 3'd1,
    FT_SLOW_RISE = 3'd2,
    FT_SLOW_FALL = 3'd3,
    FT_FAST_RISE = 3'd4,
    FT_FAST_FALL = 3'd5,
    FT_HOLD      = 3'd6,
    FT_NONE      = 3'd7
  } fault_e;

  typedef struct packed {
    logic sim;
    logic known;
    logic obs;
    logic neg;
  } cell_t;
endpackage

// File: rtl/scb_stream_ctl.sv
module scb_stream_ctl
  import scb_pkg::*;
#(
  parameter int CHAIN_LEN = 2048,
  localparam int IDX_W = $clog2(CHAIN_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       fault_i,
  input  logic             valid_i,
  input  logic             final_pat_i,
  input  cell_t            cell_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             pair_ok_o,
  output cell_t            prev_o,
  output fault_e           fault_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHAIN_LEN - 1);
  localparam logic [IDX_W-1:0] ONE_IDX  = IDX_W'(1);

  logic             busy_q, busy_n;
  logic             done_q, done_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  cell_t            prev_q, prev_n;
  fault_e           fault_q, fault_n;
  logic             accept, last_cell, en;

  assign accept    = valid_i && busy_q;
  assign last_cell = (idx_q == LAST_IDX);
  assign en        = start_i || accept;

  always_comb begin
    busy_n  = busy_q;
    done_n  = done_q;
    idx_n   = idx_q;
    prev_n  = prev_q;
    fault_n = fault_q;
    if (start_i) begin
      busy_n  = 1'b1;
      done_n  = 1'b0;
      idx_n   = '0;
      fault_n = fault_e'(fault_i);
    end else if (accept) begin
      prev_n = cell_i;
      idx_n  = last_cell ? '0 : idx_q + ONE_IDX;
      if (last_cell && final_pat_i) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      idx_q   <= '0;
      prev_q  <= '0;
      fault_q <= FT_SA0;
    end else if (en) begin
      busy_q  <= busy_n;
      done_q  <= done_n;
      idx_q   <= idx_n;
      prev_q  <= prev_n;
      fault_q <= fault_n;
    end
  end

  assign ready_o   = busy_q;
  assign accept_o  = accept;
  assign done_o    = done_q;
  assign idx_o     = idx_q;
  assign pair_ok_o = (idx_q != '0);
  assign prev_o    = prev_q;
  assign fault_o   = fault_q;

  a_r11_done_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  a_r10_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !start_i && !last_cell) |=> (idx_q == $past(idx_q) + ONE_IDX));
  a_r8_idx_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !start_i && last_cell) |=> (idx_q == '0));
  a_r10_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !start_i) |=> $stable(idx_q));
endmodule

// File: rtl/scb_cell_judge.sv
module scb_cell_judge
  import scb_pkg::*;
#(
  parameter int CHAIN_LEN = 2048,
  localparam int IDX_W = $clog2(CHAIN_LEN)
) (
  input  fault_e           fault_i,
  input  cell_t            cur_i,
  input  cell_t            prev_i,
  input  logic             pair_ok_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             lo_vld_o,
  output logic [IDX_W:0]   lo_val_o,
  output logic             hi_vld_o,
  output logic [IDX_W-1:0] hi_val_o
);
  localparam logic [IDX_W:0]   ONE_L = (IDX_W+1)'(1);
  localparam logic [IDX_W-1:0] ONE_I = IDX_W'(1);

  logic       norm_c, norm_p, match_c, match_p, pair_use, act;
  logic [2:0] code;

  assign code    = fault_i;
  assign norm_c  = cur_i.sim ^ cur_i.neg;
  assign norm_p  = prev_i.sim ^ prev_i.neg;
  assign match_c = (cur_i.obs == cur_i.sim);
  assign match_p = (prev_i.obs == prev_i.sim);
  assign pair_use = pair_ok_i && cur_i.known && prev_i.known && act;

  always_comb begin
    case (fault_i)
      FT_SLOW_RISE, FT_FAST_RISE: act = !norm_p && norm_c;
      FT_SLOW_FALL, FT_FAST_FALL: act = norm_p && !norm_c;
      FT_HOLD:                    act = (prev_i.sim != cur_i.sim);
      default:                    act = 1'b0;
    endcase
  end

  always_comb begin
    lo_vld_o = 1'b0;
    hi_vld_o = 1'b0;
    lo_val_o = '0;
    hi_val_o = '0;
    if (fault_i == FT_SA0 || fault_i == FT_SA1) begin
      if (cur_i.known && (norm_c != code[0])) begin
        if (match_c) begin
          lo_vld_o = 1'b1;
          lo_val_o = {1'b0, idx_i} + ONE_L;
        end else begin
          hi_vld_o = 1'b1;
          hi_val_o = idx_i;
        end
      end
    end else if (pair_use) begin
      if (match_c && match_p) begin
        lo_vld_o = 1'b1;
        lo_val_o = {1'b0, idx_i};
      end else begin
        hi_vld_o = 1'b1;
        hi_val_o = idx_i - ONE_I;
      end
    end
  end
endmodule

// File: rtl/scb_bound_track.sv
module scb_bound_track #(
  parameter int CHAIN_LEN = 2048,
  localparam int IDX_W = $clog2(CHAIN_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             upd_i,
  input  logic             lo_vld_i,
  input  logic [IDX_W:0]   lo_val_i,
  input  logic             hi_vld_i,
  input  logic [IDX_W-1:0] hi_val_i,
  output logic [IDX_W:0]   lo_o,
  output logic [IDX_W-1:0] hi_o,
  output logic             conflict_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHAIN_LEN - 1);

  logic [IDX_W:0]   lo_q, lo_n;
  logic [IDX_W-1:0] hi_q, hi_n;
  logic             conf_q, conf_n, en;

  assign en = start_i || upd_i;

  always_comb begin
    lo_n   = lo_q;
    hi_n   = hi_q;
    conf_n = conf_q;
    if (start_i) begin
      lo_n   = '0;
      hi_n   = LAST_IDX;
      conf_n = 1'b0;
    end else if (upd_i) begin
      if (lo_vld_i && (lo_val_i > lo_q)) lo_n = lo_val_i;
      if (hi_vld_i && (hi_val_i < hi_q)) hi_n = hi_val_i;
      conf_n = conf_q || (lo_n > {1'b0, hi_n});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= LAST_IDX;
      conf_q <= 1'b0;
    end else if (en) begin
      lo_q   <= lo_n;
      hi_q   <= hi_n;
      conf_q <= conf_n;
    end
  end

  assign lo_o       = lo_q;
  assign hi_o       = hi_q;
  assign conflict_o = conf_q;

  a_r8_lo_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (lo_q >= $past(lo_q)));
  a_r8_hi_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (hi_q <= $past(hi_q)));
  a_r9_conflict_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (conf_q && !start_i) |=> conf_q);
  a_r9_conflict_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    !conf_q |-> (lo_q <= {1'b0, hi_q}));
  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (lo_q == '0 && hi_q == LAST_IDX && !conf_q));
endmodule

// File: rtl/scan_suspect_bounder.sv
module scan_suspect_bounder
  import scb_pkg::*;
#(
  parameter int CHAIN_LEN = 2048,
  localparam int IDX_W = $clog2(CHAIN_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       fault_i,
  input  logic             cell_valid_i,
  input  logic             cell_sim_i,
  input  logic             cell_known_i,
  input  logic             cell_obs_i,
  input  logic             cell_neg_i,
  input  logic             final_pat_i,
  output logic             cell_ready_o,
  output logic [IDX_W:0]   lo_o,
  output logic [IDX_W-1:0] hi_o,
  output logic             conflict_o,
  output logic             done_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_s;
  cell_t            cur, prev;
  fault_e           fault_q;
  logic             accept, pair_ok;
  logic [IDX_W-1:0] idx;
  logic             lo_vld, hi_vld;
  logic [IDX_W:0]   lo_val;
  logic [IDX_W-1:0] hi_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  assign cur = '{sim: cell_sim_i, known: cell_known_i, obs: cell_obs_i, neg: cell_neg_i};

  scb_stream_ctl #(.CHAIN_LEN(CHAIN_LEN)) ctl_i (
    .clk(clk), .rst_n(rst_s), .start_i(start_i), .fault_i(fault_i),
    .valid_i(cell_valid_i), .final_pat_i(final_pat_i), .cell_i(cur),
    .ready_o(cell_ready_o), .accept_o(accept), .done_o(done_o),
    .idx_o(idx), .pair_ok_o(pair_ok), .prev_o(prev), .fault_o(fault_q)
  );

  scb_cell_judge #(.CHAIN_LEN(CHAIN_LEN)) judge_i (
    .fault_i(fault_q), .cur_i(cur), .prev_i(prev), .pair_ok_i(pair_ok),
    .idx_i(idx), .lo_vld_o(lo_vld), .lo_val_o(lo_val),
    .hi_vld_o(hi_vld), .hi_val_o(hi_val)
  );

  scb_bound_track #(.CHAIN_LEN(CHAIN_LEN)) track_i (
    .clk(clk), .rst_n(rst_s), .start_i(start_i), .upd_i(accept),
    .lo_vld_i(lo_vld), .lo_val_i(lo_val), .hi_vld_i(hi_vld), .hi_val_i(hi_val),
    .lo_o(lo_o), .hi_o(hi_o), .conflict_o(conflict_o)
  );

  a_r2_unknown_ignored: assert property (@(posedge clk) disable iff (!rst_s)
    (accept && !cell_known_i && !start_i) |=> ($stable(lo_o) && $stable(hi_o)));
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (!accept && !start_i) |=> ($stable(lo_o) && $stable(hi_o) && $stable(conflict_o)));
  a_r4_one_side: assert property (@(posedge clk) disable iff (!rst_s)
    !(lo_vld && hi_vld));
  a_r7_no_rule_code: assert property (@(posedge clk) disable iff (!rst_s)
    (fault_q == FT_NONE && !start_i) |=> ($stable(lo_o) && $stable(hi_o)));
endmodule

// File: tb/scan_suspect_bounder_tb.sv
module scan_suspect_bounder_tb_top;
  localparam int N = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [2:0] fault_i = 3'd0;
  logic cell_valid_i = 1'b0, cell_sim_i = 1'b0, cell_known_i = 1'b0;
  logic cell_obs_i = 1'b0, cell_neg_i = 1'b0, final_pat_i = 1'b0;
  logic cell_ready_o, conflict_o, done_o;
  logic [IW:0] lo_o;
  logic [IW-1:0] hi_o;

  int checks = 0, fails = 0, cyc = 0;
  int m_lo, m_hi, m_idx, m_ft;
  bit m_conf, m_done;
  bit p_sim, p_known, p_obs, p_neg;
  logic [15:0] lf = 16'hACE1;

  scan_suspect_bounder #(.CHAIN_LEN(N)) dut_i (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  function automatic logic [15:0] lfsr_step(input logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lo = 0; m_hi = N - 1; m_conf = 0; m_idx = 0; m_done = 0;
  endtask

  task automatic do_start(input int ft);
    @(negedge clk);
    start_i = 1'b1; fault_i = 3'(ft);
    @(negedge clk);
    start_i = 1'b0;
    m_ft = ft;
    model_reset();
  endtask

  // drive one cell at a falling edge; the rising edge between takes it
  task automatic push(input bit sim, input bit known, input bit obs, input bit neg, input bit fin);
    bit norm, pnorm, act;
    cell_sim_i = sim; cell_known_i = known; cell_obs_i = obs;
    cell_neg_i = neg; final_pat_i = fin; cell_valid_i = 1'b1;
    if (cell_ready_o) begin
      norm = sim ^ neg; pnorm = p_sim ^ p_neg;
      if (m_ft <= 1) begin
        if (known && (norm != (m_ft % 2))) begin
          if (obs == sim) begin if (m_idx + 1 > m_lo) m_lo = m_idx + 1; end
          else if (m_idx < m_hi) m_hi = m_idx;
        end
      end else if (m_ft <= 6 && m_idx > 0 && known && p_known) begin
        case (m_ft)
          2, 4: act = !pnorm && norm;
          3, 5: act = pnorm && !norm;
          default: act = (p_sim != sim);
        endcase
        if (act) begin
          if (obs == sim && p_obs == p_sim) begin if (m_idx > m_lo) m_lo = m_idx; end
          else if (m_idx - 1 < m_hi) m_hi = m_idx - 1;
        end
      end
      if (m_lo > m_hi) m_conf = 1;
      p_sim = sim; p_known = known; p_obs = obs; p_neg = neg;
      if (m_idx == N - 1) begin
        if (fin) m_done = 1;
        m_idx = 0;
      end else m_idx++;
    end
    @(negedge clk);
    cell_valid_i = 1'b0;
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " lo"}, int'(lo_o), m_lo);
    chk({tag, " hi"}, int'(hi_o), m_hi);
    chk({tag, " conflict"}, int'(conflict_o), int'(m_conf));
  endtask

  initial begin
    m_ft = 0; model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 reset lo", int'(lo_o), 0);
    chk("R1 reset hi", int'(hi_o), N - 1);
    chk("R1 reset conflict", int'(conflict_o), 0);
    chk("R1 reset ready", int'(cell_ready_o), 0);
    chk("R1 reset done", int'(done_o), 0);

    // R10 offered while not ready: a mismatching stuck-at-0 cell would set hi
    push(1, 1, 0, 0, 0);
    push(1, 1, 1, 0, 0);
    chk("R10 idle lo", int'(lo_o), 0);
    chk("R10 idle hi", int'(hi_o), N - 1);

    // R3 R4: stuck-at-1 at cell 3, cell 2 negative polarity
    do_start(1);
    chk("R1 ready after start", int'(cell_ready_o), 1);
    push(0, 1, 0, 0, 1); push(0, 1, 0, 0, 1); push(1, 1, 1, 1, 1);
    push(0, 1, 1, 0, 1);
    chk("R4 lo after cells 0..3", int'(lo_o), 3);
    chk("R4 hi after cells 0..3", int'(hi_o), 3);
    for (int c = 4; c < N; c++) push(0, 1, 1, 0, 1);
    chk("R3 sa1 lo", int'(lo_o), 3);
    chk("R3 sa1 hi", int'(hi_o), 3);
    chk("R11 done", int'(done_o), 1);
    chk("R11 ready low", int'(cell_ready_o), 0);
    push(0, 1, 1, 0, 0);
    chk("R10 after done hi", int'(hi_o), 3);
    chk("R10 after done lo", int'(lo_o), 3);

    // R5 R6: slow rise, alternating stream, mismatch from cell 5
    do_start(2);
    chk("R1 restart lo", int'(lo_o), 0);
    push(0,1,0,0,1); push(1,1,1,0,1); push(0,1,0,0,1); push(1,1,1,0,1);
    push(0,1,0,0,1); push(1,1,0,0,1); push(0,1,0,0,1); push(1,1,0,0,1);
    chk("R6 str lo", int'(lo_o), 3);
    chk("R6 str hi", int'(hi_o), 4);

    // R2 all unknown
    do_start(0);
    for (int c = 0; c < 4; c++) push(1, 0, 0, 0, 1);
    chk("R2 mid hi", int'(hi_o), N - 1);
    for (int c = 4; c < N; c++) push(1, 0, 0, 0, 1);
    chk("R2 unknown lo", int'(lo_o), 0);
    chk("R2 unknown hi", int'(hi_o), N - 1);

    // R9 conflict
    do_start(0);
    for (int c = 0; c < N - 1; c++) push(0, 0, 0, 0, 0);
    push(1, 1, 1, 0, 0);
    chk("R9 lo at N", int'(lo_o), N);
    chk("R9 conflict set", int'(conflict_o), 1);
    push(1, 1, 0, 0, 1);
    chk("R9 hi 0", int'(hi_o), 0);
    for (int c = 1; c < N; c++) push(0, 0, 0, 0, 1);
    chk("R9 conflict sticky", int'(conflict_o), 1);

    // R8 no pair across pattern boundary
    do_start(2);
    for (int c = 0; c < N - 1; c++) push(0, 0, 0, 0, 0);
    push(0, 1, 0, 0, 0);
    push(1, 1, 0, 0, 1);
    for (int c = 1; c < N; c++) push(0, 0, 0, 0, 1);
    chk("R8 boundary lo", int'(lo_o), 0);
    chk("R8 boundary hi", int'(hi_o), N - 1);

    // R7 hold uses raw values; R5 transition uses normalised values
    do_start(6);
    push(1, 1, 1, 0, 1); push(0, 1, 0, 1, 1);
    for (int c = 2; c < N; c++) push(0, 0, 0, 0, 1);
    chk("R7 hold lo", int'(lo_o), 1);
    chk("R7 hold hi", int'(hi_o), N - 1);
    do_start(2);
    push(1, 1, 1, 0, 1); push(0, 1, 0, 1, 1);
    chk("R5 no activation hi", int'(hi_o), N - 1);
    chk("R5 no activation lo", int'(lo_o), 0);
    do_start(2);
    push(0, 1, 0, 0, 1); push(0, 1, 1, 1, 1);
    chk("R5 polarity pair hi", int'(hi_o), 0);

    // R3..R9 sweep over every code
    for (int ft = 0; ft < 8; ft++) begin
      for (int run = 0; run < 4; run++) begin
        do_start(ft);
        for (int pat = 0; pat < 3; pat++) begin
          for (int c = 0; c < N; c++) begin
            lf = lfsr_step(lf);
            push(lf[2], lf[1:0] != 2'b00, lf[2] ^ (lf[6:4] == 3'd0 || (run == 3 && lf[8])),
                 lf[3], pat == 2);
          end
          chk_state("R8 sweep");
        end
        chk("R11 sweep done", int'(done_o), int'(m_done));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule